// File: doc/BRIEF.md
# UART Register Bank with Interrupts

This block is the byte-wide, software-visible face of a 16550-style serial port. A host reaches its eight registers through a simple read/write bus. The bus address is shifted right by a configurable stride before the register offset is decoded. Bytes written for transmission leave on an outgoing strobe. Bytes from the line arrive on a valid/ready stream. A single interrupt line reports transmit-ready and receive-available conditions.

The line control register is decoded into word length, stop-bit length and parity mode for a serializer outside this block. Its top bit switches offsets 0 and 1 over to the two bytes of the baud divisor. The transmitter is modelled as always ready. A transmit-ready flag is set by certain control writes and cleared by reading the identification register. A loopback bit in the modem control register routes written bytes back to the receive side.

Top module: `uart_regbank`

## Requirements
- R1: The register offset is `bus_addr >> STRIDE_SHIFT`. An access whose offset is 8 or more changes no state, reads 0, raises no `tx_valid` and no `rx_ready`.
- R2: While line-control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes its high byte. These accesses replace the data and interrupt-enable registers. The divisor appears on the `divisor` port.
- R3: After reset the divisor is 12 and line control is 0x03. Interrupt enable, modem control, FIFO control, the status stores, scratch and `irq` are 0.
- R4: `word_len` = 5 + lcr[1:0]. `stop_half` is 2 when lcr[2] = 0, is 3 when lcr[2] = 1 with lcr[1:0] = 0, and is 4 otherwise. `par_on` = lcr[3]. `par_kind` = lcr[5:4], where 0 is odd, 1 is even, 2 is forced zero and 3 is forced one. `brk` = lcr[6].
- R5: An interrupt is pending when (ier[1] and the transmit-ready flag) or (ier[0] and a byte is available). The identification register at offset 2 reads {fcr[0], fcr[0], 3'b000, byte available, transmit-ready flag, not pending}.
- R6: `irq` is a register loaded every cycle with (pending and mcr[3]). It follows a change of state one cycle later.
- R7: A read of offset 2 returns the current identification value and then clears the transmit-ready flag. A write of offset 2 loads the FIFO control register.
- R8: The transmit-ready flag is set by three events: a data write (offset 0 with lcr[7] = 0); an offset-1 write with lcr[7] = 0 that changes ier[1] from 0 to 1; a modem-control write with bit 3 set.
- R9: A data write with mcr[4] = 0 drives `tx_valid` = 1 and `tx_data` = the byte in that same cycle. With mcr[4] = 1 the byte is held for the receive side and `tx_valid` stays 0.
- R10: A line-status read returns the stored byte with bits 6 and 5 forced to 1 and bit 0 replaced by byte-available. A modem-status read returns the stored byte with bits 7, 5 and 4 forced to 1.
- R11: A data read takes a held loopback byte first. If none is held, `rx_ready` is 1 in that cycle and the read returns `rx_data` when `rx_valid` is 1, or 0 when no byte is offered.
- R12: Interrupt enable, line control, modem control and the scratch register at offset 7 read back the last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, scaled by the stride |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Received byte taken |
| irq | output | 1 | Interrupt request |
| divisor | output | 16 | Baud divisor |
| word_len | output | 4 | Data bits per character (5 to 8) |
| stop_half | output | 3 | Stop length in half bits |
| par_on | output | 1 | Parity bit present |
| par_kind | output | 2 | Parity kind |
| brk | output | 1 | Break requested |

## Verification
On every cycle the assertions check four things: out-of-range accesses stay silent, `irq` is never raised without the modem-control gate, loopback keeps the transmit strobe quiet, and line status always reports an empty transmitter. They also check that an identification read clears the transmit-ready flag, that a data write sets it, and that an empty data read returns zero. The bench's scenarios are needed for the ordered effects: the one-cycle lag of `irq`, the set and clear sequence of the transmit-ready flag across control writes, the loopback byte taking priority over the stream, divisor banking, and every line-control decode.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int ADDR_W = 8,
  parameter int STRIDE_SHIFT = 0,
  parameter logic [15:0] DIV_INIT = 16'd12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              irq,
  output logic [15:0]       divisor,
  output logic [3:0]        word_len,
  output logic [2:0]        stop_half,
  output logic              par_on,
  output logic [1:0]        par_kind,
  output logic              brk
);
  logic [ADDR_W-1:0] off;
  logic [2:0] idx;
  logic in_rng, wr, rd, dlab, avail, pending, txf, lb_v;
  logic [7:0] ier_q, lcr_q, mcr_q, fcr_q, lsr_q, msr_q, scr_q, lb_d;
  logic [15:0] div_q;

  assign off    = bus_addr >> STRIDE_SHIFT;
  assign idx    = off[2:0];
  assign in_rng = off < ADDR_W'(8);
  assign wr     = bus_sel && bus_we && in_rng;
  assign rd     = bus_sel && !bus_we && in_rng;
  assign dlab   = lcr_q[7];
  assign avail  = lb_v || rx_valid;
  assign pending = (ier_q[1] && txf) || (ier_q[0] && avail);

  assign tx_valid = wr && idx == 3'd0 && !dlab && !mcr_q[4];
  assign tx_data  = bus_wdata;
  assign rx_ready = rd && idx == 3'd0 && !dlab && !lb_v;

  assign divisor   = div_q;
  assign word_len  = 4'd5 + {2'b00, lcr_q[1:0]};
  assign stop_half = !lcr_q[2] ? 3'd2 : (lcr_q[1:0] == 2'd0 ? 3'd3 : 3'd4);
  assign par_on    = lcr_q[3];
  assign par_kind  = lcr_q[5:4];
  assign brk       = lcr_q[6];

  always_comb begin
    bus_rdata = 8'h00;
    if (rd) begin
      case (idx)
        3'd0: bus_rdata = dlab ? div_q[7:0] : (lb_v ? lb_d : (rx_valid ? rx_data : 8'h00));
        3'd1: bus_rdata = dlab ? div_q[15:8] : ier_q;
        3'd2: bus_rdata = {fcr_q[0], fcr_q[0], 3'b000, avail, txf, !pending};
        3'd3: bus_rdata = lcr_q;
        3'd4: bus_rdata = mcr_q;
        3'd5: bus_rdata = {lsr_q[7], 2'b11, lsr_q[4:1], avail};
        3'd6: bus_rdata = msr_q | 8'hB0;
        default: bus_rdata = scr_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_INIT;
      lcr_q <= 8'h03;
      ier_q <= '0; mcr_q <= '0; fcr_q <= '0;
      lsr_q <= '0; msr_q <= '0; scr_q <= '0;
      txf <= 1'b0; lb_v <= 1'b0; lb_d <= '0;
      irq <= 1'b0;
    end else begin
      irq <= pending && mcr_q[3];
      if (wr) begin
        case (idx)
          3'd0: if (dlab) div_q[7:0] <= bus_wdata;
                else begin
                  txf <= 1'b1;
                  if (mcr_q[4]) begin lb_v <= 1'b1; lb_d <= bus_wdata; end
                end
          3'd1: if (dlab) div_q[15:8] <= bus_wdata;
                else begin
                  if (!ier_q[1] && bus_wdata[1]) txf <= 1'b1;
                  ier_q <= bus_wdata;
                end
          3'd2: fcr_q <= bus_wdata;
          3'd3: lcr_q <= bus_wdata;
          3'd4: begin mcr_q <= bus_wdata; if (bus_wdata[3]) txf <= 1'b1; end
          3'd5: lsr_q <= bus_wdata;
          3'd6: msr_q <= bus_wdata;
          default: scr_q <= bus_wdata;
        endcase
      end else if (rd) begin
        if (idx == 3'd2) txf <= 1'b0;
        if (idx == 3'd0 && !dlab && lb_v) lb_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int ADDR_W = 8,
  parameter int STRIDE_SHIFT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [7:0]        mcr_q,
  input logic [7:0]        lcr_q,
  input logic              txf,
  input logic              lb_v
);
  logic [ADDR_W-1:0] c_off;
  assign c_off = bus_addr >> STRIDE_SHIFT;

  AST_BAD_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && c_off >= ADDR_W'(8)) |-> (bus_rdata == 8'h00 && !tx_valid && !rx_ready)); // R1
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mcr_q[3])); // R6
  AST_IIR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && c_off == ADDR_W'(2)) |=> !txf); // R7
  AST_DATA_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && c_off == ADDR_W'(0) && !lcr_q[7]) |=> txf); // R8
  AST_LOOP_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mcr_q[4]); // R9
  AST_LSR_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && c_off == ADDR_W'(5)) |-> bus_rdata[6:5] == 2'b11); // R10
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && c_off == ADDR_W'(0) && !lcr_q[7] && !rx_valid && !lb_v)
      |-> bus_rdata == 8'h00); // R11
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .STRIDE_SHIFT(STRIDE_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tx_valid(tx_valid), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq(irq), .mcr_q(mcr_q), .lcr_q(lcr_q), .txf(txf), .lb_v(lb_v)
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
  localparam int CLK_P = 10;
  localparam int SH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, rx_valid = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, rx_data = '0;
  logic [7:0] bus_rdata, tx_data, par_kind_unused;
  logic tx_valid, rx_ready, irq, par_on, brk;
  logic [15:0] divisor;
  logic [3:0] word_len;
  logic [2:0] stop_half;
  logic [1:0] par_kind;

  always #(CLK_P/2) clk = ~clk;

  uart_regbank #(.ADDR_W(8), .STRIDE_SHIFT(SH)) u_uart_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .irq(irq),
    .divisor(divisor), .word_len(word_len), .stop_half(stop_half), .par_on(par_on),
    .par_kind(par_kind), .brk(brk));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_div, m_lcr, m_ier, m_mcr, m_fcr, m_lsr, m_msr, m_scr, m_lbd;
  bit m_txf, m_lbv, m_irq;
  int rxq[$];
  int last_rd;
  bit last_txv, last_rxr, last_irq;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit sel, bit we, int addr, int wd);
    int off, e_rd, stp;
    bit inr, r, w, dl, av, pend;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = 8'(addr); bus_wdata = 8'(wd);
    rx_valid = rxq.size() > 0;
    rx_data = rx_valid ? 8'(rxq[0]) : 8'h00;
    #1;
    off = addr >> SH; inr = off < 8;
    r = sel && !we && inr; w = sel && we && inr;
    dl = m_lcr[7]; av = m_lbv || rxq.size() > 0;
    pend = (m_ier[1] && m_txf) || (m_ier[0] && av);
    e_rd = 0;
    if (r) case (off)
      0: e_rd = dl ? (m_div & 255) : (m_lbv ? m_lbd : (rxq.size() > 0 ? rxq[0] : 0));
      1: e_rd = dl ? (m_div >> 8) : m_ier;
      2: e_rd = (m_fcr[0] ? 8'hC0 : 0) + (av ? 4 : 0) + (m_txf ? 2 : 0) + (pend ? 0 : 1);
      3: e_rd = m_lcr;
      4: e_rd = m_mcr;
      5: e_rd = ((m_lsr | 8'h60) & 8'hFE) | (av ? 1 : 0);
      6: e_rd = m_msr | 8'hB0;
      default: e_rd = m_scr;
    endcase
    chk("R1 rdata", 32'(bus_rdata), 32'(e_rd));
    chk("R9 tx_valid", 32'(tx_valid), 32'(w && off == 0 && !dl && !m_mcr[4]));
    if (tx_valid) chk("R9 tx_data", 32'(tx_data), 32'(wd));
    chk("R11 rx_ready", 32'(rx_ready), 32'(r && off == 0 && !dl && !m_lbv));
    chk("R6 irq", 32'(irq), 32'(m_irq));
    chk("R2 divisor", 32'(divisor), 32'(m_div));
    stp = !m_lcr[2] ? 2 : ((m_lcr & 3) == 0 ? 3 : 4);
    chk("R4 word_len", 32'(word_len), 32'(5 + (m_lcr & 3)));
    chk("R4 stop_half", 32'(stop_half), 32'(stp));
    chk("R4 parity", 32'({par_on, par_kind, brk}), 32'({m_lcr[3], m_lcr[5], m_lcr[4], m_lcr[6]}));
    last_rd = bus_rdata; last_txv = tx_valid; last_rxr = rx_ready; last_irq = irq;
    m_irq = pend && m_mcr[3];
    if (w) case (off)
      0: if (dl) m_div = (m_div & 16'hFF00) | wd;
         else begin m_txf = 1; if (m_mcr[4]) begin m_lbv = 1; m_lbd = wd; end end
      1: if (dl) m_div = (m_div & 255) | (wd << 8);
         else begin if (!m_ier[1] && wd[1]) m_txf = 1; m_ier = wd; end
      2: m_fcr = wd;
      3: m_lcr = wd;
      4: begin m_mcr = wd; if (wd[3]) m_txf = 1; end
      5: m_lsr = wd;
      6: m_msr = wd;
      default: m_scr = wd;
    endcase
    if (r && off == 2) m_txf = 0;
    if (r && off == 0 && !dl) begin
      if (m_lbv) m_lbv = 0;
      else if (rxq.size() > 0) void'(rxq.pop_front());
    end
  endtask

  task automatic wr(int o, int d); cyc(1, 1, o << SH, d); endtask
  task automatic rd(int o); cyc(1, 0, o << SH, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0); endtask
  task automatic settle(); @(posedge clk); #1; endtask

  initial begin
    m_div = 12; m_lcr = 3; m_ier = 0; m_mcr = 0; m_fcr = 0; m_lsr = 0; m_msr = 0;
    m_scr = 0; m_lbd = 0; m_txf = 0; m_lbv = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk("R3 reset divisor", 32'(divisor), 32'd12);
    chk("R3 reset irq", 32'(irq), 32'd0);
    rd(3); chk("R3 reset lcr", last_rd, 32'h03);
    rd(2); chk("R5 iir idle", last_rd, 32'h01);
    wr(3, 8'h83); rd(0); chk("R2 div low", last_rd, 32'd12);
    rd(1); chk("R2 div high", last_rd, 32'd0);
    wr(0, 8'h34); wr(1, 8'h12); settle();
    chk("R2 divisor port", 32'(divisor), 32'h1234);
    wr(3, 8'h03); rd(1); chk("R12 ier after dlab", last_rd, 32'h00);
    wr(3, 8'h04); settle(); chk("R4 stop 1.5", 32'(stop_half), 32'd3);
    wr(3, 8'h07); settle(); chk("R4 stop 2", 32'(stop_half), 32'd4);
    wr(3, 8'h2B); settle(); chk("R4 forced zero", 32'({par_on, par_kind}), 32'b110);
    wr(3, 8'h43); settle(); chk("R4 break", 32'(brk), 32'd1);
    wr(3, 8'h03);
    wr(1, 8'h02); idle(); idle(); chk("R6 gated off", 32'(last_irq), 32'd0);
    rd(2); chk("R5 iir tx pending", last_rd, 32'h02);
    rd(2); chk("R7 iir cleared", last_rd, 32'h01);
    wr(4, 8'h08); idle(); chk("R6 one cycle lag", 32'(last_irq), 32'd0);
    idle(); chk("R8 mcr sets flag", 32'(last_irq), 32'd1);
    rd(2); idle(); idle(); chk("R7 irq drops", 32'(last_irq), 32'd0);
    wr(0, 8'h41); chk("R9 tx strobe", 32'(last_txv), 32'd1);
    idle(); idle(); chk("R8 data write sets", 32'(last_irq), 32'd1);
    rd(2);
    wr(1, 8'h01); rxq.push_back(8'h5A); idle(); idle(); idle();
    chk("R5 rx interrupt", 32'(last_irq), 32'd1);
    rd(0); chk("R11 rx byte", last_rd, 32'h5A); chk("R11 rx_ready", 32'(last_rxr), 32'd1);
    rd(0); chk("R11 empty read", last_rd, 32'h00);
    wr(4, 8'h18); wr(0, 8'h77); chk("R9 loopback no tx", 32'(last_txv), 32'd0);
    rxq.push_back(8'h11);
    rd(5); chk("R10 lsr rx ready", last_rd, 32'h61);
    rd(0); chk("R11 loopback first", last_rd, 32'h77);
    rd(0); chk("R11 stream after loop", last_rd, 32'h11);
    rd(5); chk("R10 lsr idle", last_rd, 32'h60);
    wr(5, 8'h1F); rd(5); chk("R10 lsr stored", last_rd, 32'h7E);
    wr(6, 8'h00); rd(6); chk("R10 msr forced", last_rd, 32'hB0);
    wr(7, 8'hA5); rd(7); chk("R12 scratch", last_rd, 32'hA5);
    rd(4); chk("R12 mcr readback", last_rd, 32'h18);
    cyc(1, 1, 32, 8'h3C); rd(7); chk("R1 bad offset write", last_rd, 32'hA5);
    cyc(1, 0, 32, 0); chk("R1 bad offset read", last_rd, 32'h00);
    cyc(1, 0, 29, 0); chk("R1 stride divide", last_rd, 32'hA5);
    wr(2, 8'h01); rd(2); chk("R7 fcr loaded", last_rd >> 6, 32'd3);
    idle(); idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule